// File: doc/BRIEF.md
# Streaming-to-bus burst data coupler

This block ties the data phase of a bus master's burst to a client-side streaming handshake, with no FIFO between them. A command gives a direction and a beat count. On a read, every beat the bus slave acknowledges passes through one register stage onto the client's read stream. On a write, the client's stream drives the bus data lines directly, and each beat is consumed in the cycle the slave acknowledges it. Because nothing is buffered, the slave's pace sets the stream's pace. The slave may stall on any cycle. The client may not stall once its stream has started, and the block flags any attempt to do so.

All stream framing and handshake signals are active-low. The block frames read streams from its own beat counter. It checks the framing the client supplies on write streams against the same counter. A transfer finishes on the cycle where end-of-frame, source-ready and destination-ready are all asserted together. One cycle later a single-cycle completion strobe appears, and the block is ready for the next command on the cycle after that.

Top module: `stream_bus_coupler`

## Requirements
- R1: While and after a synchronous active-high `rst`, `cmd_ready` is 1, `cmd_done`, `proto_err` and `bus_wr_req` are 0, and every active-low stream output (`rd_sof_n`, `rd_eof_n`, `rd_src_rdy_n`, `wr_dst_rdy_n`) is 1.
- R2: During a read, a beat acknowledged by `bus_rd_ack` in cycle t appears on `rd_data` with `rd_src_rdy_n` low in cycle t+1. Beats keep their order. In a cycle following a slave stall, after the previous beat was taken, `rd_src_rdy_n` is high.
- R3: On a read, `rd_sof_n` is low only on the first beat, and `rd_eof_n` is low only on the beat whose number equals the command length. A one-beat read has both low on the same beat.
- R4: On a read, the final beat keeps `rd_src_rdy_n`, `rd_eof_n` and `rd_data` unchanged until the client drives `rd_dst_rdy_n` low.
- R5: On a write, `bus_wr_data` equals `wr_data` in the same cycle. `bus_wr_req` is high while a write is active and `wr_src_rdy_n` is low. `wr_dst_rdy_n` is low exactly in the cycles where `bus_wr_req` and `bus_wr_ack` are both high, so a slave stall holds it high.
- R6: A transfer ends only in a cycle where its stream's eof, source-ready and destination-ready are all low. `cmd_done` is high for exactly the next cycle, and `cmd_ready` is high on the cycle after that.
- R7: After the first beat of a stream has been exchanged and before it ends, `proto_err` is high in any cycle where the client's ready is high (`rd_dst_rdy_n` on reads, `wr_src_rdy_n` on writes) or its discontinue input (`rd_disc_n` or `wr_disc_n`) is low. It is low before the first beat.
- R8: On a write beat exchange, `proto_err` is high if the client's `wr_eof_n` low disagrees with the beat being the last one by count, or if `wr_sof_n` low disagrees with the beat being the first. The write still ends on the client's eof.
- R9: A command length of 0 is treated as one beat.
- R10: `bus_rearb` has no effect on any output.
- R11: A command is accepted only while `cmd_ready` is 1. `cmd_valid` raised during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_len | input | LEN_W | Beat count (0 means 1) |
| cmd_ready | output | 1 | Idle, command can be taken |
| cmd_done | output | 1 | One-cycle completion strobe |
| proto_err | output | 1 | Client protocol violation this cycle |
| bus_rd_data | input | DW | Read data from bus slave |
| bus_rd_ack | input | 1 | Slave delivers a read beat |
| bus_wr_data | output | DW | Write data to bus slave |
| bus_wr_req | output | 1 | Write beat offered to slave |
| bus_wr_ack | input | 1 | Slave consumes the write beat |
| bus_rearb | input | 1 | Rearbitrate status (ignored) |
| rd_data | output | DW | Read stream data |
| rd_sof_n | output | 1 | Read start of frame, active-low |
| rd_eof_n | output | 1 | Read end of frame, active-low |
| rd_src_rdy_n | output | 1 | Read beat valid, active-low |
| rd_dst_rdy_n | input | 1 | Client ready for read beat, active-low |
| rd_disc_n | input | 1 | Client read discontinue, active-low |
| wr_data | input | DW | Write stream data |
| wr_sof_n | input | 1 | Write start of frame, active-low |
| wr_eof_n | input | 1 | Write end of frame, active-low |
| wr_src_rdy_n | input | 1 | Client write beat valid, active-low |
| wr_dst_rdy_n | output | 1 | Write beat consumed, active-low |
| wr_disc_n | input | 1 | Client write discontinue, active-low |

## Verification
On a write, a slave acknowledge and the client's final eof beat can fall in the same cycle. That one cycle must both consume the beat on the bus and end the stream, so `cmd_done` has to follow exactly one cycle later. The bench creates this by ending write bursts on an acknowledged beat after stall patterns. It also ends a burst early with eof on a beat the count does not call last, where the end and a protocol-error flag coincide. The scoreboard judges the data consumed, the end cycle recorded by the monitor, the strobe timing and the error count. On reads, a new slave beat and the client's take of the previous beat share a cycle in back-to-back bursts, and the in-order scoreboard compares each pair.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } sbc_state_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } sbc_dir_e;

    // Per-direction beat event: a beat was exchanged, it closed the stream,
    // and a client protocol violation is seen this cycle.
    typedef struct packed {
        logic fire;
        logic fin;
        logic err;
    } sbc_evt_t;

    // A zero-length command moves one beat.
    function automatic int unsigned eff_len(input int unsigned n);
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             rd_fire,
    input  logic             rd_fin,
    input  logic             wr_fire,
    input  logic             wr_fin,
    output logic             cmd_ready,
    output logic             cmd_done,
    output logic             in_rd,
    output logic             in_wr,
    output logic             first,
    output logic [LEN_W-1:0] rem
);

    sbc_state_e state;
    sbc_dir_e   dir;
    logic       fire;
    logic       fin;

    assign fire      = (dir == DIR_WR) ? wr_fire : rd_fire;
    assign fin       = (dir == DIR_WR) ? wr_fin  : rd_fin;
    assign cmd_ready = (state == ST_IDLE);
    assign cmd_done  = (state == ST_DONE);
    assign in_rd     = (state == ST_BUSY) && (dir == DIR_RD);
    assign in_wr     = (state == ST_BUSY) && (dir == DIR_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dir   <= DIR_RD;
            rem   <= '0;
            first <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        state <= ST_BUSY;
                        dir   <= sbc_dir_e'(cmd_write);
                        rem   <= LEN_W'(eff_len(32'(cmd_len)));
                        first <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (fire) begin
                        first <= 1'b0;
                        rem   <= (rem == '0) ? '0 : rem - LEN_W'(1);
                        if (fin) state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: the completion strobe lasts a single cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);

    // R11: an accepted command makes the block busy on the next cycle
    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (!cmd_ready && !cmd_done));

endmodule

// File: rtl/sbc_rd_path.sv
module sbc_rd_path
    import sbc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_rd,
    input  logic             first,
    input  logic [LEN_W-1:0] rem,
    input  logic [DW-1:0]    bus_rd_data,
    input  logic             bus_rd_ack,
    input  logic             rd_dst_rdy_n,
    input  logic             rd_disc_n,
    output logic [DW-1:0]    rd_data,
    output logic             rd_sof_n,
    output logic             rd_eof_n,
    output logic             rd_src_rdy_n,
    output sbc_evt_t         evt
);

    logic [DW-1:0] beat_q;
    logic          beat_v;
    logic          last;
    logic          take;

    assign last = (rem == LEN_W'(1));
    assign take = beat_v && !rd_dst_rdy_n;

    // One register stage: a new slave beat wins over the client's take.
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            beat_v <= 1'b0;
        end else if (in_rd && bus_rd_ack) begin
            beat_q <= bus_rd_data;
            beat_v <= 1'b1;
        end else if (take) begin
            beat_v <= 1'b0;
        end
    end

    assign rd_data      = beat_q;
    assign rd_src_rdy_n = !beat_v;
    assign rd_sof_n     = !(beat_v && first);
    assign rd_eof_n     = !(beat_v && last);

    always_comb begin
        evt.fire = take;
        evt.fin  = take && last;
        evt.err  = in_rd && !first && (rd_dst_rdy_n || !rd_disc_n);
    end

    // R4: the final beat stays put while the client holds off
    assert_hold_last_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_src_rdy_n && !rd_eof_n && rd_dst_rdy_n && !bus_rd_ack)
        |=> (!rd_src_rdy_n && !rd_eof_n && $stable(rd_data)));

    // R2: an acknowledged slave beat is offered on the next cycle
    assert_beat_follows_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (in_rd && bus_rd_ack) |=> !rd_src_rdy_n);

endmodule

// File: rtl/sbc_wr_path.sv
module sbc_wr_path
    import sbc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 8
) (
    input  logic             in_wr,
    input  logic             first,
    input  logic [LEN_W-1:0] rem,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_sof_n,
    input  logic             wr_eof_n,
    input  logic             wr_src_rdy_n,
    input  logic             wr_disc_n,
    input  logic             bus_wr_ack,
    output logic [DW-1:0]    bus_wr_data,
    output logic             bus_wr_req,
    output logic             wr_dst_rdy_n,
    output sbc_evt_t         evt
);

    logic last;
    logic hs;
    logic frame_bad;

    // Straight wires: the beat after a stall is on the bus the cycle it ends.
    assign bus_wr_data  = wr_data;
    assign bus_wr_req   = in_wr && !wr_src_rdy_n;
    assign hs           = bus_wr_req && bus_wr_ack;
    assign wr_dst_rdy_n = !hs;
    assign last         = (rem == LEN_W'(1));
    assign frame_bad    = (!wr_eof_n != last) || (!wr_sof_n != first);

    always_comb begin
        evt.fire = hs;
        evt.fin  = hs && !wr_eof_n;
        evt.err  = (in_wr && !first && (wr_src_rdy_n || !wr_disc_n))
                 || (hs && frame_bad);
    end

endmodule

// File: rtl/stream_bus_coupler.sv
module stream_bus_coupler
    import sbc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             cmd_ready,
    output logic             cmd_done,
    output logic             proto_err,
    input  logic [DW-1:0]    bus_rd_data,
    input  logic             bus_rd_ack,
    output logic [DW-1:0]    bus_wr_data,
    output logic             bus_wr_req,
    input  logic             bus_wr_ack,
    input  logic             bus_rearb,
    output logic [DW-1:0]    rd_data,
    output logic             rd_sof_n,
    output logic             rd_eof_n,
    output logic             rd_src_rdy_n,
    input  logic             rd_dst_rdy_n,
    input  logic             rd_disc_n,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_sof_n,
    input  logic             wr_eof_n,
    input  logic             wr_src_rdy_n,
    output logic             wr_dst_rdy_n,
    input  logic             wr_disc_n
);

    sbc_evt_t         rd_evt;
    sbc_evt_t         wr_evt;
    logic             in_rd;
    logic             in_wr;
    logic             first;
    logic [LEN_W-1:0] rem;
    logic             unused_rearb;

    // Rearbitration status carries no meaning for the data phase.
    assign unused_rearb = bus_rearb;
    assign proto_err    = rd_evt.err || wr_evt.err;

    sbc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_len   (cmd_len),
        .rd_fire   (rd_evt.fire),
        .rd_fin    (rd_evt.fin),
        .wr_fire   (wr_evt.fire),
        .wr_fin    (wr_evt.fin),
        .cmd_ready (cmd_ready),
        .cmd_done  (cmd_done),
        .in_rd     (in_rd),
        .in_wr     (in_wr),
        .first     (first),
        .rem       (rem)
    );

    sbc_rd_path #(.DW(DW), .LEN_W(LEN_W)) u_rd (
        .clk          (clk),
        .rst          (rst),
        .in_rd        (in_rd),
        .first        (first),
        .rem          (rem),
        .bus_rd_data  (bus_rd_data),
        .bus_rd_ack   (bus_rd_ack),
        .rd_dst_rdy_n (rd_dst_rdy_n),
        .rd_disc_n    (rd_disc_n),
        .rd_data      (rd_data),
        .rd_sof_n     (rd_sof_n),
        .rd_eof_n     (rd_eof_n),
        .rd_src_rdy_n (rd_src_rdy_n),
        .evt          (rd_evt)
    );

    sbc_wr_path #(.DW(DW), .LEN_W(LEN_W)) u_wr (
        .in_wr        (in_wr),
        .first        (first),
        .rem          (rem),
        .wr_data      (wr_data),
        .wr_sof_n     (wr_sof_n),
        .wr_eof_n     (wr_eof_n),
        .wr_src_rdy_n (wr_src_rdy_n),
        .wr_disc_n    (wr_disc_n),
        .bus_wr_ack   (bus_wr_ack),
        .bus_wr_data  (bus_wr_data),
        .bus_wr_req   (bus_wr_req),
        .wr_dst_rdy_n (wr_dst_rdy_n),
        .evt          (wr_evt)
    );

    // R6: a read stream closing handshake is followed by the strobe
    assert_rd_end_done_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd_eof_n && !rd_src_rdy_n && !rd_dst_rdy_n) |=> cmd_done);

    // R6: a write stream closing handshake is followed by the strobe
    assert_wr_end_done_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_eof_n && !wr_src_rdy_n && !wr_dst_rdy_n) |=> cmd_done);

    // R5: a slave stall keeps the write beat unconsumed
    assert_wr_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_req && !bus_wr_ack) |-> wr_dst_rdy_n);

endmodule

// File: tb/sim_stream_bus_coupler.sv
module sim_stream_bus_coupler;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int LW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_ready, cmd_done, proto_err;
    logic [DW-1:0] bus_rd_data = '0;
    logic          bus_rd_ack = 1'b0;
    logic [DW-1:0] bus_wr_data;
    logic          bus_wr_req;
    logic          bus_wr_ack = 1'b0, bus_rearb = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_sof_n, rd_eof_n, rd_src_rdy_n;
    logic          rd_dst_rdy_n = 1'b0, rd_disc_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          wr_sof_n = 1'b1, wr_eof_n = 1'b1, wr_src_rdy_n = 1'b1;
    logic          wr_dst_rdy_n;
    logic          wr_disc_n = 1'b1;

    int checks = 0, fails = 0, done_cnt = 0, err_cnt = 0;
    longint cyc = 0, end_cyc = -10;

    typedef struct packed { logic [DW-1:0] d; logic s; logic e; } rbeat_t;
    rbeat_t        rq[$];
    logic [DW-1:0] wq[$];

    stream_bus_coupler #(.DW(DW), .LEN_W(LW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expectations when the design delivers beats.
    rbeat_t mb;
    logic [DW-1:0] mw;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!rd_src_rdy_n && !rd_dst_rdy_n) begin
                if (rq.size() == 0) chk(0, "R2", "unexpected read beat", rd_data, 0);
                else begin
                    mb = rq.pop_front();
                    chk(rd_data == mb.d, "R2", "read data order", rd_data, mb.d);
                    chk(rd_sof_n == !mb.s, "R3", "read sof_n", rd_sof_n, !mb.s);
                    chk(rd_eof_n == !mb.e, "R3", "read eof_n", rd_eof_n, !mb.e);
                end
                if (!rd_eof_n) end_cyc = cyc;
            end
            if (bus_wr_req && bus_wr_ack) begin
                if (wq.size() == 0) chk(0, "R5", "unexpected write beat", bus_wr_data, 0);
                else begin
                    mw = wq.pop_front();
                    chk(bus_wr_data == mw, "R5", "bus write data", bus_wr_data, mw);
                end
                chk(!wr_dst_rdy_n, "R5", "dst_rdy_n on consumed beat", wr_dst_rdy_n, 0);
                if (!wr_eof_n) end_cyc = cyc;
            end
            if (cmd_done)  done_cnt++;
            if (proto_err) err_cnt++;
        end
    end

    task automatic smp();
        @(negedge clk); #1;
    endtask

    task automatic nxt();
        @(posedge clk); #1;
    endtask

    task automatic issue(input bit w, input int len);
        nxt();
        cmd_valid = 1'b1; cmd_write = w; cmd_len = LW'(len);
        nxt();
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        do begin smp(); n++; end while (!cmd_done && n < 200);
        chk(cmd_done, req, "completion strobe seen", cmd_done, 1);
        chk(cyc == end_cyc + 1, req, "strobe one cycle after end", cyc, end_cyc + 1);
        smp();
        chk(!cmd_done, "R6", "strobe lasts one cycle", cmd_done, 0);
        chk(cmd_ready, "R6", "ready after strobe", cmd_ready, 1);
    endtask

    task automatic read_burst(input int len, input bit [31:0] pat,
                              input logic [DW-1:0] base, input bit rearb, input string req);
        int n = (len == 0) ? 1 : len;
        int k = 0, c = 0;
        bit prev = 0;
        int d0 = done_cnt;
        issue(1'b0, len);
        while (k < n) begin
            bus_rd_ack = pat[c % 32];
            bus_rearb  = rearb ? c[0] : 1'b0;
            if (bus_rd_ack) begin
                bus_rd_data = base + DW'(k);
                rq.push_back('{d: base + DW'(k), s: (k == 0), e: (k == n - 1)});
            end
            smp();
            if (!prev) chk(rd_src_rdy_n, "R2", "no beat after stall", rd_src_rdy_n, 1);
            prev = bus_rd_ack;
            if (bus_rd_ack) k++;
            c++;
            nxt();
        end
        bus_rd_ack = 1'b0; bus_rearb = 1'b0;
        wait_done(req);
        chk(rq.size() == 0, req, "all read beats delivered", rq.size(), 0);
        chk(done_cnt == d0 + 1, req, "one completion per read", done_cnt, d0 + 1);
    endtask

    task automatic write_burst(input int len, input int beats, input bit [31:0] pat,
                               input logic [DW-1:0] base, input string req);
        int k = 0, c = 0;
        for (int i = 0; i < beats; i++) wq.push_back(base + DW'(i));
        issue(1'b1, len);
        while (k < beats) begin
            wr_src_rdy_n = 1'b0;
            wr_data  = base + DW'(k);
            wr_sof_n = (k != 0);
            wr_eof_n = (k != beats - 1);
            bus_wr_ack = pat[c % 32];
            smp();
            chk(bus_wr_data == wr_data, "R5", "write data passes through", bus_wr_data, wr_data);
            chk(bus_wr_req, "R5", "write request with source ready", bus_wr_req, 1);
            if (!bus_wr_ack) chk(wr_dst_rdy_n, "R5", "stall holds dst_rdy_n", wr_dst_rdy_n, 1);
            if (!wr_dst_rdy_n) k++;
            c++;
            nxt();
        end
        wr_src_rdy_n = 1'b1; wr_sof_n = 1'b1; wr_eof_n = 1'b1; bus_wr_ack = 1'b0;
        wait_done(req);
        chk(wq.size() == 0, req, "all write beats consumed", wq.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int e0;
        repeat (3) nxt();
        smp();
        chk(cmd_ready && !cmd_done && !proto_err, "R1", "idle during reset", {cmd_ready, cmd_done, proto_err}, 3'b100);
        rst = 1'b0;
        smp();
        chk(cmd_ready, "R1", "cmd_ready after reset", cmd_ready, 1);
        chk(rd_src_rdy_n && rd_sof_n && rd_eof_n, "R1", "read outputs idle", {rd_src_rdy_n, rd_sof_n, rd_eof_n}, 3'b111);
        chk(wr_dst_rdy_n && !bus_wr_req, "R1", "write outputs idle", {wr_dst_rdy_n, bus_wr_req}, 2'b10);

        // R2 R3: back-to-back and stalled reads
        read_burst(4, 32'hFFFF_FFFF, 16'h1100, 1'b0, "R6");
        read_burst(5, 32'b1011_0101, 16'h2200, 1'b0, "R6");
        read_burst(1, 32'b0001, 16'h3300, 1'b0, "R3");
        // R9: zero length reads one beat
        read_burst(0, 32'b1, 16'h4400, 1'b0, "R9");
        // R10: rearbitrate toggling leaves the stream intact
        read_burst(6, 32'b1101_1011, 16'h5500, 1'b1, "R10");

        // R4: final beat held until client is ready
        rd_dst_rdy_n = 1'b1;
        issue(1'b0, 1);
        bus_rd_ack = 1'b1; bus_rd_data = 16'hABCD;
        rq.push_back('{d: 16'hABCD, s: 1'b1, e: 1'b1});
        nxt();
        bus_rd_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            smp();
            chk(!rd_src_rdy_n && !rd_eof_n && !rd_sof_n, "R4", "final beat held",
                {rd_src_rdy_n, rd_eof_n, rd_sof_n}, 0);
            chk(rd_data == 16'hABCD, "R4", "held data", rd_data, 16'hABCD);
            chk(!cmd_done, "R4", "no completion while held", cmd_done, 0);
            nxt();
        end
        rd_dst_rdy_n = 1'b0;
        wait_done("R4");

        // R5 R6: writes with stalls, ends on an acknowledged eof beat
        write_burst(4, 4, 32'hFFFF_FFFF, 16'h6600, "R6");
        write_burst(5, 5, 32'b0110_1001_1, 16'h7700, "R6");
        write_burst(1, 1, 32'b100, 16'h8800, "R6");
        write_burst(0, 1, 32'b1, 16'h8900, "R9");

        // R8: client eof arrives one beat early
        e0 = err_cnt;
        write_burst(3, 2, 32'hFFFF_FFFF, 16'h9900, "R8");
        chk(err_cnt == e0 + 1, "R8", "early eof flagged once", err_cnt, e0 + 1);

        // R7: write throttle and discontinue after the first beat
        e0 = err_cnt;
        wq.push_back(16'hA000); wq.push_back(16'hA001);
        issue(1'b1, 2);
        smp();
        chk(!proto_err, "R7", "no error before first beat", proto_err, 0);
        nxt();
        wr_src_rdy_n = 1'b0; wr_sof_n = 1'b0; wr_data = 16'hA000; bus_wr_ack = 1'b1;
        nxt();
        wr_src_rdy_n = 1'b1; wr_sof_n = 1'b1; bus_wr_ack = 1'b0;
        smp();
        chk(proto_err, "R7", "write source throttle flagged", proto_err, 1);
        nxt();
        wr_src_rdy_n = 1'b0; wr_data = 16'hA001; wr_disc_n = 1'b0;
        smp();
        chk(proto_err, "R7", "write discontinue flagged", proto_err, 1);
        nxt();
        wr_disc_n = 1'b1; wr_eof_n = 1'b0; bus_wr_ack = 1'b1;
        smp();
        chk(!proto_err, "R7", "clean final beat", proto_err, 0);
        nxt();
        wr_src_rdy_n = 1'b1; wr_eof_n = 1'b1; bus_wr_ack = 1'b0;
        wait_done("R7");
        chk(err_cnt == e0 + 2, "R7", "write error cycles", err_cnt, e0 + 2);

        // R7: read client throttle and discontinue after the first beat
        e0 = err_cnt;
        issue(1'b0, 3);
        bus_rd_ack = 1'b1; bus_rd_data = 16'hB000;
        rq.push_back('{d: 16'hB000, s: 1'b1, e: 1'b0});
        nxt();
        bus_rd_ack = 1'b0;
        smp();
        chk(!proto_err, "R7", "first read beat taken cleanly", proto_err, 0);
        nxt();
        rd_dst_rdy_n = 1'b1;
        smp();
        chk(proto_err, "R7", "read client throttle flagged", proto_err, 1);
        nxt();
        rd_dst_rdy_n = 1'b0; rd_disc_n = 1'b0;
        bus_rd_ack = 1'b1; bus_rd_data = 16'hB001;
        rq.push_back('{d: 16'hB001, s: 1'b0, e: 1'b0});
        smp();
        chk(proto_err, "R7", "read discontinue flagged", proto_err, 1);
        nxt();
        rd_disc_n = 1'b1; bus_rd_data = 16'hB002;
        rq.push_back('{d: 16'hB002, s: 1'b0, e: 1'b1});
        nxt();
        bus_rd_ack = 1'b0;
        wait_done("R7");
        chk(err_cnt == e0 + 2, "R7", "read error cycles", err_cnt, e0 + 2);

        // R11: a command request during a read is ignored
        e0 = done_cnt;
        issue(1'b0, 2);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_len = 8'd5;
        bus_rd_ack = 1'b1; bus_rd_data = 16'hC000;
        rq.push_back('{d: 16'hC000, s: 1'b1, e: 1'b0});
        smp();
        chk(!cmd_ready, "R11", "busy during transfer", cmd_ready, 0);
        nxt();
        bus_rd_data = 16'hC001;
        rq.push_back('{d: 16'hC001, s: 1'b0, e: 1'b1});
        smp();
        chk(!bus_wr_req, "R11", "no write started by ignored command", bus_wr_req, 0);
        nxt();
        cmd_valid = 1'b0; bus_rd_ack = 1'b0;
        wait_done("R11");
        chk(done_cnt == e0 + 1, "R11", "only the read completed", done_cnt, e0 + 1);
        smp();
        chk(cmd_ready, "R11", "still idle afterwards", cmd_ready, 1);

        chk(rq.size() == 0 && wq.size() == 0, "R2", "scoreboard empty", rq.size() + wq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule